// File: doc/BRIEF.md
# Display Palette Lookup Register

This block translates the pixel index of a bit-plane display into drive signals for a monitor. Three plane bits, fetched in parallel from video memory for the same pixel, form a 3-bit index. The block uses that index to select one of eight programmable entries. Each entry holds a 3-bit colour number. On every pixel clock the selected colour number is registered and presented in two forms: as separate green, red and blue drive bits for a colour monitor, and as a gradation level for a monochrome monitor.

The host programs the entries with I/O write cycles. The block decodes the I/O address itself. The eight entries live at odd addresses in two groups of four. The base address 0x140 is a parameter, and the entries sit at base+1, +3, +5, +7, +0x11, +0x13, +0x15 and +0x17. Only three bits in the upper byte of the data word carry the colour number. The internal write enable is active low. It is formed from the address match and the active-low I/O write strobe. A lookup can run in the same cycle as a write to the same entry; in that case it returns the data being written.

A separate active-low read enable gates the outputs. When that enable is inactive, the output stage marks the pixel as not valid and drives all colour outputs to zero, which stands in for a floating bus.

Top module: `palette_lut`

## Requirements
- R1: After synchronous reset, all eight entries hold colour number 0. Every pixel index with the read enable active therefore gives rgb = 0 and mono_level = 0.
- R2: An I/O write with io_wr_n low to an address in {base+0x01, +0x03, +0x05, +0x07} writes entries 0 to 3 in that order. A write to {base+0x11, +0x13, +0x15, +0x17} writes entries 4 to 7. The default base is 0x140, so the addresses are 0x141..0x147 and 0x151..0x157.
- R3: The stored colour number is io_wdata[10:8], with bit 10 as the most significant bit. All other data bits have no effect on the stored value.
- R4: The colour outputs decode the colour number c as rgb_b = c[0], rgb_r = c[1] and rgb_g = c[2].
- R5: mono_level is 0 for colour number 0 and 8 − c for c = 1..7, so white (7) gives level 1.
- R6: While io_wr_n is high, no entry changes, whatever the address and data are.
- R7: A write with io_wr_n low to any address outside the eight entry addresses leaves all entries unchanged.
- R8: If a write and a lookup hit the same entry in the same cycle, the registered output shows the newly written colour number in the following cycle.
- R9: The outputs are registered. The colour for the plane bits presented at a clock edge appears just after that edge and stays stable until the next edge.
- R10: When rd_en_n is high at a clock edge, pix_valid is 0 after that edge and rgb_r, rgb_g, rgb_b and mono_level are all 0. When rd_en_n is low, pix_valid is 1.
- R11: A write changes only the addressed entry. The other seven entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 16 | Host data bus; colour number taken from bits 10:8 |
| io_wr_n | input | 1 | I/O write command strobe, active low |
| plane_bits | input | 3 | Plane bits of the current pixel (palette index) |
| rd_en_n | input | 1 | Output enable, active low |
| rgb_r | output | 1 | Red drive |
| rgb_g | output | 1 | Green drive |
| rgb_b | output | 1 | Blue drive |
| mono_level | output | 3 | Monochrome gradation level |
| pix_valid | output | 1 | High when the outputs are driven |

## Verification
The host write and the pixel lookup are the two functions that can meet in one clock cycle. They collide when the written entry is also the entry the current pixel selects. The bench provokes this by presenting io_wr_n low, a matching address and a plane index equal to that entry in the same cycle. The entry is preloaded with a different colour beforehand. The output after that edge must carry the new colour, not the stale one. A second pixel read of the same entry then confirms that the write also landed in storage.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int PAL_ENTRIES = 8;
    localparam int PAL_IDX_W   = $clog2(PAL_ENTRIES);
    localparam int COLOUR_W    = 3;
    localparam int GRAY_W      = 3;

    typedef logic [COLOUR_W-1:0]  colour_t;
    typedef logic [PAL_IDX_W-1:0] pal_idx_t;
    typedef logic [GRAY_W-1:0]    gray_t;

    typedef struct packed {
        logic g;
        logic r;
        logic b;
    } rgb_t;

    typedef struct packed {
        logic  valid;
        rgb_t  rgb;
        gray_t gray;
    } pix_out_t;

    // colour number bit 0 drives blue, bit 1 red, bit 2 green
    function automatic rgb_t colour_to_rgb(input colour_t c);
        rgb_t o;
        o.b = c[0];
        o.r = c[1];
        o.g = c[2];
        return o;
    endfunction

    // black stays dark, brighter colours map to lower gradation codes
    function automatic gray_t colour_to_gray(input colour_t c);
        logic [COLOUR_W:0] diff;
        diff = (COLOUR_W+1)'(PAL_ENTRIES) - {1'b0, c};
        if (c == '0)
            return '0;
        return diff[GRAY_W-1:0];
    endfunction

    localparam pix_out_t PIX_DARK = '{valid: 1'b0, rgb: '{g: 1'b0, r: 1'b0, b: 1'b0}, gray: '0};

endpackage

// File: rtl/pal_host_decode.sv
module pal_host_decode
    import pal_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PAL_BASE = ADDR_W'('h140)
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr_n,
    output logic              pal_we_n,
    output pal_idx_t          pal_wr_idx
);

    // address bits that select the entry: 1,2 (word in group) and 4 (group)
    localparam int GRP_BIT  = 4;
    localparam logic [ADDR_W-1:0] SEL_MASK  = ADDR_W'('h16);
    localparam logic [ADDR_W-1:0] MATCH_VAL = (PAL_BASE & ~SEL_MASK) | ADDR_W'(1);

    logic cs_hit;

    always_comb begin
        cs_hit     = ((io_addr & ~SEL_MASK) == MATCH_VAL);
        pal_wr_idx = {io_addr[GRP_BIT], io_addr[2:1]};
        // active-low write enable: chip select gated with write strobe
        pal_we_n   = io_wr_n | ~cs_hit;
    end

endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
    import pal_pkg::*;
#(
    parameter int ENTRIES = PAL_ENTRIES,
    parameter int WIDTH   = COLOUR_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_n,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WIDTH-1:0]         rd_data,
    output logic [ENTRIES*WIDTH-1:0] ent_flat
);

    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                mem[i] <= '0;
        end else if (!we_n) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign ent_flat[g*WIDTH +: WIDTH] = mem[g];
    end

    // flow-through: a write to the selected word is visible on the read side
    always_comb begin
        if (!we_n && (wr_idx == rd_idx))
            rd_data = wr_data;
        else
            rd_data = mem[rd_idx];
    end

endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage
    import pal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd_en_n,
    input  colour_t  colour,
    output pix_out_t pix_q
);

    pix_out_t pix_d;

    always_comb begin
        if (rd_en_n) begin
            pix_d = PIX_DARK;
        end else begin
            pix_d.valid = 1'b1;
            pix_d.rgb   = colour_to_rgb(colour);
            pix_d.gray  = colour_to_gray(colour);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_q <= PIX_DARK;
        else
            pix_q <= pix_d;
    end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import pal_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 16,
    parameter int                DATA_LSB = 8,
    parameter logic [ADDR_W-1:0] PAL_BASE = ADDR_W'('h140)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr_n,
    input  logic [2:0]        plane_bits,
    input  logic              rd_en_n,
    output logic              rgb_r,
    output logic              rgb_g,
    output logic              rgb_b,
    output logic [2:0]        mono_level,
    output logic              pix_valid
);

    logic                               pal_we_n;
    pal_idx_t                           pal_wr_idx;
    colour_t                            wr_colour;
    colour_t                            rd_colour;
    logic [PAL_ENTRIES*COLOUR_W-1:0]    ent_flat;
    pix_out_t                           pix_q;
    logic                               unused_bus_bits;

    assign wr_colour       = io_wdata[DATA_LSB +: COLOUR_W];
    assign unused_bus_bits = ^io_wdata;

    pal_host_decode #(
        .ADDR_W   (ADDR_W),
        .PAL_BASE (PAL_BASE)
    ) u_decode (
        .io_addr    (io_addr),
        .io_wr_n    (io_wr_n),
        .pal_we_n   (pal_we_n),
        .pal_wr_idx (pal_wr_idx)
    );

    pal_regfile #(
        .ENTRIES (PAL_ENTRIES),
        .WIDTH   (COLOUR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we_n     (pal_we_n),
        .wr_idx   (pal_wr_idx),
        .wr_data  (wr_colour),
        .rd_idx   (plane_bits),
        .rd_data  (rd_colour),
        .ent_flat (ent_flat)
    );

    pal_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .rd_en_n (rd_en_n),
        .colour  (rd_colour),
        .pix_q   (pix_q)
    );

    assign rgb_r      = pix_q.rgb.r;
    assign rgb_g      = pix_q.rgb.g;
    assign rgb_b      = pix_q.rgb.b;
    assign mono_level = pix_q.gray;
    assign pix_valid  = pix_q.valid;

endmodule

// File: rtl/pal_checker.sv
module pal_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PAL_BASE = ADDR_W'('h140)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic [2:0]        wr_colour,
    input logic              io_wr_n,
    input logic [2:0]        plane_bits,
    input logic              rd_en_n,
    input logic [23:0]       ent_flat,
    input logic              rgb_r,
    input logic              rgb_g,
    input logic              rgb_b,
    input logic [2:0]        mono_level,
    input logic              pix_valid
);

    logic       hit;
    logic [2:0] hit_idx;
    logic       armed;
    logic       last_hit;
    logic [2:0] last_idx;
    logic [2:0] last_data;
    logic [2:0] col_now;

    // address table built arithmetically, independent of the mask decode
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < 8; i++) begin
            if (io_addr == PAL_BASE + ADDR_W'(1 + 2 * (i % 4) + 16 * (i / 4))) begin
                hit     = 1'b1;
                hit_idx = 3'(i);
            end
        end
    end

    assign col_now = {rgb_g, rgb_r, rgb_b};

    always_ff @(posedge clk) begin
        armed <= !rst;
        if (rst) begin
            last_hit  <= 1'b0;
            last_idx  <= '0;
            last_data <= '0;
        end else begin
            last_hit  <= hit && !io_wr_n;
            last_idx  <= hit_idx;
            last_data <= wr_colour;
        end
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        last_hit |-> (ent_flat[int'(last_idx)*3 +: 3] == last_data));

    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        io_wr_n |=> $stable(ent_flat));

    p_miss_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        (!io_wr_n && !hit) |=> $stable(ent_flat));

    p_flow_through_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (!io_wr_n && hit && !rd_en_n && (plane_bits == hit_idx)) |=> (col_now == $past(wr_colour)));

    p_off_invalid_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        rd_en_n |=> !pix_valid);

    p_on_valid_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        !rd_en_n |=> pix_valid);

    p_dark_when_off_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        !pix_valid |-> (col_now == 3'd0 && mono_level == 3'd0));

    p_gray_scale_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        pix_valid |-> (mono_level == ((col_now == 3'd0) ? 3'd0 : 3'(4'd8 - {1'b0, col_now}))));

endmodule

bind palette_lut pal_checker #(
    .ADDR_W   (ADDR_W),
    .PAL_BASE (PAL_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_addr    (io_addr),
    .wr_colour  (io_wdata[DATA_LSB +: 3]),
    .io_wr_n    (io_wr_n),
    .plane_bits (plane_bits),
    .rd_en_n    (rd_en_n),
    .ent_flat   (ent_flat),
    .rgb_r      (rgb_r),
    .rgb_g      (rgb_g),
    .rgb_b      (rgb_b),
    .mono_level (mono_level),
    .pix_valid  (pix_valid)
);

// File: tb/palette_lut_tb.sv
module palette_lut_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic        io_wr_n = 1'b1;
    logic [2:0]  plane_bits = '0;
    logic        rd_en_n = 1'b0;
    logic        rgb_r, rgb_g, rgb_b, pix_valid;
    logic [2:0]  mono_level;

    int checks = 0;
    int errors = 0;
    logic [2:0] model [8];

    always #2 clk = ~clk;

    palette_lut u_dut (
        .clk        (clk),
        .rst        (rst),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr_n    (io_wr_n),
        .plane_bits (plane_bits),
        .rd_en_n    (rd_en_n),
        .rgb_r      (rgb_r),
        .rgb_g      (rgb_g),
        .rgb_b      (rgb_b),
        .mono_level (mono_level),
        .pix_valid  (pix_valid)
    );

    // {valid, g, r, b, level}
    function automatic logic [6:0] expect_pix(input logic [2:0] c);
        logic [2:0] lvl;
        lvl = (c == 3'd0) ? 3'd0 : 3'(4'd8 - {1'b0, c});
        return {1'b1, c[2], c[1], c[0], lvl};
    endfunction

    function automatic logic [15:0] entry_addr(input int i);
        logic [15:0] a [8] = '{16'h0141, 16'h0143, 16'h0145, 16'h0147,
                               16'h0151, 16'h0153, 16'h0155, 16'h0157};
        return a[i];
    endfunction

    function automatic logic [6:0] actual_pix();
        return {pix_valid, rgb_g, rgb_r, rgb_b, mono_level};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] addr, input logic [15:0] data);
        @(negedge clk);
        io_addr  = addr;
        io_wdata = data;
        io_wr_n  = 1'b0;
        @(negedge clk);
        io_wr_n  = 1'b1;
    endtask

    task automatic look(input int idx, input string req);
        @(negedge clk);
        plane_bits = 3'(idx);
        rd_en_n    = 1'b0;
        @(posedge clk);
        #1;
        chk(req, actual_pix(), expect_pix(model[idx]));
    endtask

    task automatic look_all(input string req);
        for (int i = 0; i < 8; i++)
            look(i, req);
    endtask

    // R1
    task automatic t_reset();
        for (int i = 0; i < 8; i++) model[i] = 3'd0;
        look_all("R1 reset black");
    endtask

    // R2 R3 R4 R5: every entry with junk in the unused data bits
    task automatic t_load_all();
        logic [2:0] vals [8] = '{3'd5, 3'd1, 3'd7, 3'd2, 3'd6, 3'd3, 3'd0, 3'd4};
        for (int i = 0; i < 8; i++) begin
            host_write(entry_addr(i), {5'b10110, vals[i], 8'hA5});
            model[i] = vals[i];
        end
        look_all("R2 R3 R4 R5 load all entries");
    endtask

    // R11: single overwrite leaves the rest
    task automatic t_single();
        host_write(16'h0153, {5'b11111, 3'd6, 8'hFF});
        model[5] = 3'd6;
        look_all("R11 single entry overwrite");
    endtask

    // R6: address and data present, strobe inactive
    task automatic t_strobe_idle();
        @(negedge clk);
        io_addr  = 16'h0145;
        io_wdata = {5'd0, 3'd0, 8'd0};
        io_wr_n  = 1'b1;
        repeat (3) @(negedge clk);
        look(2, "R6 no strobe no write");
    endtask

    // R7: near-miss addresses
    task automatic t_bad_addr();
        logic [15:0] bad [6] = '{16'h0140, 16'h0149, 16'h0159, 16'h0161, 16'h0341, 16'h1151};
        for (int i = 0; i < 6; i++)
            host_write(bad[i], {5'd0, 3'd1, 8'd0});
        look_all("R7 foreign address ignored");
    endtask

    // R8: write and lookup of the same entry in one cycle
    task automatic t_flow();
        @(negedge clk);
        io_addr    = 16'h0147;
        io_wdata   = {5'd0, 3'd5, 8'd0};
        io_wr_n    = 1'b0;
        plane_bits = 3'd3;
        rd_en_n    = 1'b0;
        model[3]   = 3'd5;
        @(posedge clk);
        #1;
        chk("R8 flow-through same cycle", actual_pix(), expect_pix(3'd5));
        @(negedge clk);
        io_wr_n = 1'b1;
        look(3, "R8 stored after collision");
    endtask

    // R9: output holds until the next edge
    task automatic t_latency();
        look(0, "R9 first pixel");
        @(negedge clk);
        plane_bits = 3'd2;
        #1;
        chk("R9 no change before edge", actual_pix(), expect_pix(model[0]));
        @(posedge clk);
        #1;
        chk("R9 change after edge", actual_pix(), expect_pix(model[2]));
    endtask

    // R10
    task automatic t_rden();
        @(negedge clk);
        plane_bits = 3'd2;
        rd_en_n    = 1'b1;
        @(posedge clk);
        #1;
        chk("R10 disabled outputs dark", actual_pix(), 7'b0);
        look(2, "R10 re-enabled outputs");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_all();
        t_single();
        t_strobe_idle();
        t_bad_addr();
        t_flow();
        t_latency();
        t_rden();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule